// File: doc/BRIEF.md
# Serial Status LED Streamer

This block gathers link, activity, polarity and duplex status from up to eight transceiver ports and sends it out on three serial data lines that share one shift clock and one latch strobe. Each line carries a single kind of status for all ports: line 0 shows activity, line 1 polarity and line 2 duplex. A chain of external shift registers clocks the lines in and drives one LED per port and status type. The latch strobe makes every LED update at the same moment.

Each frame has one bit period per port, in port order, followed by one latch period. Frames repeat back to back. Status is captured once, at the frame boundary, so a frame never mixes old and new values. Short activity events are stretched so that they stay visible. A 2-bit select chooses one of four stretch intervals, counted in milliseconds derived from the system clock. While activity lasts, the activity LED of a linked port blinks at that interval.

Top module: `led_serial_streamer`

## Requirements
- R1: `led_clk` is a square wave that is low for `CLK_HZ/(2*LEDCLK_HZ)` system cycles and then high for the same number of cycles. It starts low when reset is released.
- R2: A frame lasts `PORTS+1` shift-clock periods. During period k, for k below `PORTS`, each data line carries port k's bit. Data changes only when `led_clk` falls.
- R3: `led_latch` is high for exactly the last period of every frame and low otherwise. All data lines are 0 while it is high.
- R4: Data bit 0 carries the activity indication, bit 1 carries the port's polarity input and bit 2 carries its duplex input.
- R5: Port inputs are captured on the system edge where the latch period ends. Input changes made at any other time do not affect the frame in progress.
- R6: A port slot whose bit is set in `UNUSED_SLOTS` sends 0 on every data line.
- R7: When a port's link is down, its activity bit is 0, whatever its activity input.
- R8: When a port's link is up and the selected interval is nonzero, its activity bit is 1 unless it is busy. A port is busy when activity is present now, or occurred in the current or the previous stretch interval.
- R9: When a linked port is busy, its activity bit equals a blink phase. The phase is 0 after reset and inverts at the end of every stretch interval.
- R10: When the selected interval is 0 ms (`STRETCH3_MS` by default), nothing is stretched and the activity bit is link AND NOT activity at capture time.
- R11: `stretch_sel` codes 0 to 3 select `STRETCH0_MS` to `STRETCH3_MS`. An interval ends after that many millisecond ticks, and a tick occurs every `CLK_HZ/1000` system cycles.
- R12: While reset is asserted, all outputs are 0. The first frame after reset sends all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| port_link | input | PORTS | Link-up flag per port |
| port_act | input | PORTS | Activity flag per port |
| port_pol | input | PORTS | Polarity status per port |
| port_dup | input | PORTS | Duplex status per port |
| stretch_sel | input | 2 | Stretch interval select |
| led_clk | output | 1 | Shift clock for the external registers |
| led_latch | output | 1 | Latch strobe, high during the last period of a frame |
| led_data | output | 3 | Serial status lines: activity, polarity, duplex |

## Verification
The bench builds the block with an 8-port width and `UNUSED_SLOTS` set to slots 3 and 4, so that the six-port layout's empty slots are covered. It sets a 4 kHz nominal system clock and a 1 kHz shift clock, which gives two cycles per half period and four cycles per millisecond tick. The stretch intervals are 2, 3, 5 and 0 ms, so every interval boundary falls at a different point inside a 36-cycle frame. Blink phase flips, busy windows and changes of the select code therefore land both inside frames and on their capture edge within a few thousand cycles.

// File: rtl/led_serial_streamer.sv
module led_serial_streamer #(
  parameter int PORTS = 8,
  parameter logic [PORTS-1:0] UNUSED_SLOTS = '0,
  parameter int CLK_HZ = 125_000_000,
  parameter int LEDCLK_HZ = 1_000_000,
  parameter int STRETCH0_MS = 30,
  parameter int STRETCH1_MS = 60,
  parameter int STRETCH2_MS = 100,
  parameter int STRETCH3_MS = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PORTS-1:0] port_link,
  input  logic [PORTS-1:0] port_act,
  input  logic [PORTS-1:0] port_pol,
  input  logic [PORTS-1:0] port_dup,
  input  logic [1:0]       stretch_sel,
  output logic             led_clk,
  output logic             led_latch,
  output logic [2:0]       led_data
);
  localparam int HALF_DIV  = CLK_HZ / (2 * LEDCLK_HZ);
  localparam int MS_CYCLES = CLK_HZ / 1000;
  localparam int DW = $clog2(HALF_DIV + 1);
  localparam int MW = $clog2(MS_CYCLES + 1);
  localparam int SW = $clog2(PORTS + 1);
  localparam int M01 = (STRETCH0_MS > STRETCH1_MS) ? STRETCH0_MS : STRETCH1_MS;
  localparam int M23 = (STRETCH2_MS > STRETCH3_MS) ? STRETCH2_MS : STRETCH3_MS;
  localparam int IMAX = (M01 > M23) ? M01 : M23;
  localparam int IW = $clog2(IMAX + 2);

  logic [DW-1:0]    div_q;
  logic             clk_q;
  logic [SW-1:0]    slot_q;
  logic [PORTS-1:0] snap_act, snap_pol, snap_dup;
  logic [MW-1:0]    ms_q;
  logic [IW-1:0]    iv_q, limit;
  logic [PORTS-1:0] cur_q, prev_q;
  logic             phase_q;

  wire half_end   = (div_q == DW'(HALF_DIV - 1));
  wire period_end = half_end & clk_q;
  wire last_slot  = (slot_q == SW'(PORTS));
  wire frame_end  = period_end & last_slot;
  wire ms_tick    = (ms_q == MW'(MS_CYCLES - 1));

  always_comb begin
    case (stretch_sel)
      2'd0:    limit = IW'(STRETCH0_MS);
      2'd1:    limit = IW'(STRETCH1_MS);
      2'd2:    limit = IW'(STRETCH2_MS);
      default: limit = IW'(STRETCH3_MS);
    endcase
  end

  wire no_stretch = (limit == '0);
  wire iv_tick = ms_tick & ~no_stretch & (({1'b0, iv_q} + 1'b1) >= {1'b0, limit});
  wire [PORTS-1:0] busy = cur_q | prev_q | port_act;
  wire [PORTS-1:0] act_view = no_stretch ? (port_link & ~port_act)
                                         : (port_link & (~busy | {PORTS{phase_q}}));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      clk_q    <= 1'b0;
      slot_q   <= '0;
      snap_act <= '0;
      snap_pol <= '0;
      snap_dup <= '0;
    end else begin
      div_q <= half_end ? '0 : div_q + 1'b1;
      if (half_end) clk_q <= ~clk_q;
      if (period_end) slot_q <= last_slot ? '0 : slot_q + 1'b1;
      if (frame_end) begin
        snap_act <= act_view & ~UNUSED_SLOTS;
        snap_pol <= port_pol & ~UNUSED_SLOTS;
        snap_dup <= port_dup & ~UNUSED_SLOTS;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ms_q    <= '0;
      iv_q    <= '0;
      cur_q   <= '0;
      prev_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      ms_q <= ms_tick ? '0 : ms_q + 1'b1;
      if (ms_tick) iv_q <= (iv_tick | no_stretch) ? '0 : iv_q + 1'b1;
      if (iv_tick) begin
        prev_q  <= cur_q | port_act;
        cur_q   <= '0;
        phase_q <= ~phase_q;
      end else begin
        cur_q <= cur_q | port_act;
      end
    end
  end

  assign led_clk   = clk_q;
  assign led_latch = last_slot;
  assign led_data[0] = ~last_slot & snap_act[0 +: PORTS] >> slot_q != '0 ? ((snap_act >> slot_q) & PORTS'(1)) != '0 : 1'b0;
  assign led_data[1] = ~last_slot & (((snap_pol >> slot_q) & PORTS'(1)) != '0);
  assign led_data[2] = ~last_slot & (((snap_dup >> slot_q) & PORTS'(1)) != '0);
endmodule

module led_serial_streamer_chk #(
  parameter int PORTS = 8,
  parameter logic [PORTS-1:0] UNUSED_SLOTS = '0,
  parameter int SW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          led_clk,
  input logic          led_latch,
  input logic [2:0]    led_data,
  input logic [SW-1:0] slot_q
);
  AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    led_latch |-> led_data == 3'b000); // R3
  AST_LATCH_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_latch) |-> $fell(led_clk)); // R3
  AST_DATA_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led_data) |-> $fell(led_clk)); // R2
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(slot_q) <= PORTS); // R2
  AST_UNUSED_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(slot_q) < PORTS && ((UNUSED_SLOTS >> slot_q) & PORTS'(1)) != '0) |-> led_data == 3'b000); // R6
endmodule

bind led_serial_streamer led_serial_streamer_chk #(
  .PORTS(PORTS), .UNUSED_SLOTS(UNUSED_SLOTS), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .led_clk(led_clk), .led_latch(led_latch),
  .led_data(led_data), .slot_q(slot_q)
);

// File: tb/led_serial_streamer_bench.sv
module led_serial_streamer_bench;
  localparam int P = 8;
  localparam logic [P-1:0] UNUSED = 8'b0001_1000;
  localparam int CHZ = 4000;
  localparam int LHZ = 1000;
  localparam int H = CHZ / (2 * LHZ);
  localparam int MS = CHZ / 1000;
  localparam int S0 = 2, S1 = 3, S2 = 5, S3 = 0;
  localparam int FRAME = 2 * H * (P + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [P-1:0] link = '0, act = '0, pol = '0, dup = '0;
  logic [1:0] sel = 2'd0;
  logic led_clk, led_latch;
  logic [2:0] led_data;

  int checks = 0, fails = 0;
  bit done = 0;
  bit check_on = 0;

  always #2 clk = ~clk;

  led_serial_streamer #(
    .PORTS(P), .UNUSED_SLOTS(UNUSED), .CLK_HZ(CHZ), .LEDCLK_HZ(LHZ),
    .STRETCH0_MS(S0), .STRETCH1_MS(S1), .STRETCH2_MS(S2), .STRETCH3_MS(S3)
  ) u_led_serial_streamer (
    .clk(clk), .rst_n(rst_n), .port_link(link), .port_act(act),
    .port_pol(pol), .port_dup(dup), .stretch_sel(sel),
    .led_clk(led_clk), .led_latch(led_latch), .led_data(led_data)
  );

  function automatic int lim_of(input logic [1:0] s); // R11
    case (s)
      2'd0: return S0;
      2'd1: return S1;
      2'd2: return S2;
      default: return S3;
    endcase
  endfunction

  function automatic string tag_of(input int code);
    case (code)
      7: return "R7";
      8: return "R8 R11";
      9: return "R9 R11";
      10: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, actual, expected, $time);
    end
  endtask

  // reference model
  int cyc, m_ms, m_iv;
  logic [P-1:0] m_cur, m_prev;
  logic m_ph;
  logic [P-1:0] e_act, e_pol, e_dup;
  int e_why [P];

  always @(posedge clk or negedge rst_n) begin : model
    int lim;
    bit mt, it;
    if (!rst_n) begin
      cyc <= 0; m_ms <= 0; m_iv <= 0; m_cur <= '0; m_prev <= '0; m_ph <= 1'b0;
      e_act <= '0; e_pol <= '0; e_dup <= '0;
      for (int p = 0; p < P; p++) e_why[p] <= 12;
    end else begin
      lim = lim_of(sel);
      mt = (m_ms == MS - 1);
      it = mt && lim != 0 && (m_iv + 1 >= lim);
      cyc <= cyc + 1;
      m_ms <= mt ? 0 : m_ms + 1;
      if (mt) m_iv <= (it || lim == 0) ? 0 : m_iv + 1;
      if (it) begin
        m_prev <= m_cur | act; m_cur <= '0; m_ph <= ~m_ph;
      end else m_cur <= m_cur | act;
      if ((cyc + 1) % FRAME == 0) begin // R5 capture edge
        for (int p = 0; p < P; p++) begin
          logic b; int w;
          if (!link[p]) begin b = 1'b0; w = 7; end
          else if (lim == 0) begin b = ~act[p]; w = 10; end
          else if (m_cur[p] | m_prev[p] | act[p]) begin b = m_ph; w = 9; end
          else begin b = 1'b1; w = 8; end
          e_act[p] <= b & ~UNUSED[p];
          e_why[p] <= w;
        end
        e_pol <= pol & ~UNUSED;
        e_dup <= dup & ~UNUSED;
      end
    end
  end

  always @(negedge clk) begin
    if (check_on && !done) begin
      int s;
      s = (cyc / (2 * H)) % (P + 1);
      check("R1", led_clk, ((cyc / H) % 2) == 1);
      check("R3", led_latch, s == P);
      if (s == P) check("R3", led_data, 0);
      else if (UNUSED[s]) check("R6", led_data, 0);
      else begin
        check({tag_of(e_why[s]), " R4 R2 R5 stream0"}, led_data[0], e_act[s]);
        check("R4 R2 R5 stream1", led_data[1], e_pol[s]);
        check("R4 R2 R5 stream2", led_data[2], e_dup[s]);
      end
    end
  end

  task automatic seg(input int n, input int s, input int act_pct, input int link_mode, input bit sel_hop);
    sel = 2'(s);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #1;
      if (sel_hop && (i % 50 == 0)) sel = 2'($urandom_range(0, 3));
      if (link_mode == 0) link = '0;
      else if (link_mode == 1) link = '1;
      else if (i % 40 == 0) link = P'($urandom);
      for (int p = 0; p < P; p++) act[p] = ($urandom_range(0, 99) < act_pct);
      if (i % 7 == 3) begin pol = P'($urandom); dup = P'($urandom); end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1ed5));
    repeat (3) @(negedge clk);
    // R12 outputs idle during reset
    check("R12", led_clk, 0);
    check("R12", led_latch, 0);
    check("R12", led_data, 0);
    link = '1; act = '1; pol = '1; dup = '1;
    @(negedge clk); rst_n = 1'b1; check_on = 1;
    seg(200, 0, 3, 1, 0);     // first frame zeros (R12), sparse activity
    seg(900, 0, 3, 1, 0);     // R8 R9 stretch 2 ms
    seg(800, 1, 40, 2, 0);    // R11 dense, random link
    seg(800, 2, 10, 2, 0);    // R11 longest interval
    seg(600, 3, 30, 2, 0);    // R10 no stretch
    seg(400, 1, 100, 0, 0);   // R7 link down, constant activity
    seg(500, 2, 0, 1, 0);     // R8 idle ports lit
    seg(1200, 0, 15, 2, 1);   // select hops
    seg(400, 0, 100, 1, 0);   // R9 steady blink
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule